// File: doc/BRIEF.md
# CD Sector Encoder and Serializer

This block turns a 2048-byte user payload into a complete 2352-byte data-CD sector and shifts it out bit by bit to a downstream disc encoder. It builds the sector on the fly, one byte at a time, with a single byte of lookahead. It generates the sync field itself. It inserts the address header and, in Mode 2 Form 1, the doubled subheader. It pulls the payload from a byte-wide buffer read port and accumulates the 32-bit error detection code as bytes pass. It inserts zero padding (Mode 1) and pulls 276 precomputed parity bytes from a second read port. It scrambles everything after the sync field and serializes the result.

The serial side runs in word-select periods of 98 bit clocks. Each half period carries six bytes and is closed by one padding bit, so a sector fills exactly 196 periods. Software starts a sector with a strobe while the block is idle. A one-cycle completion pulse marks the end of the sector. A start held high across that pulse chains the next sector with no idle time.

Top module: `cdenc_serializer`

## Requirements
- R1: A start strobe is accepted only while idle. While a sector runs, the strobe is ignored. Sector mode (modeSel 0 = Mode 1, 1 = Mode 2 Form 1), header and subheader are taken from the inputs in the accepting cycle and held for the whole sector.
- R2: Bytes 0 and 11 are 00h and bytes 1 to 10 are FFh. These sync bytes are sent unscrambled.
- R3: Bytes 12, 13 and 14 are hdrAddr[23:16], [15:8] and [7:0], and byte 15 is 01h in Mode 1 or 02h in Mode 2. In Mode 2, bytes 16 to 19 and again 20 to 23 are subHdr[31:24], [23:16], [15:8] and [7:0].
- R4: The 2048 payload bytes are read from buffer addresses 0 to 2047 in order, with data returned one cycle after bufRd. They occupy bytes 16 to 2063 in Mode 1 and 24 to 2071 in Mode 2.
- R5: The EDC is the reflected CRC with polynomial 0x8001801B (bytewise shift right, XOR D8018001h), initial value 0 and no final inversion. It covers bytes 0 to 2063 in Mode 1 and 16 to 2071 in Mode 2. It is placed directly after the payload, low byte first.
- R6: In Mode 1, bytes 2068 to 2075 are zero. In both modes, bytes 2076 to 2351 are parity port addresses 0 to 275 in order, with data returned one cycle after parRd.
- R7: Bytes 12 to 2351 are XORed with a 15-bit LFSR (x^15+x+1, state reloaded to 0001h at sector start). The LFSR output is its low state bit, applied to each byte's bit 0 first. Each step shifts the state right and puts state[0]^state[1] into bit 14.
- R8: Each serial bit lasts two system clocks. serClk is high in the second clock, serData is stable at the rising edge of serClk, and bytes go out MSB first.
- R9: wordSel is low for bit slots 0 to 48 and high for slots 49 to 97 of each 98-slot period. Slots 48 and 97 carry a 0 pad bit, and each half carries six bytes. A sector is 196 periods.
- R10: sectorDone pulses high for one cycle after the final slot of the last period. While idle, serClk, wordSel and serData are 0.
- R11: A start strobe present in the cycle sectorDone is high is accepted, and the next sector's first serClk rise follows within eight clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Begin a sector (honoured only when idle) |
| modeSel | input | 1 | 0 = Mode 1, 1 = Mode 2 Form 1 |
| hdrAddr | input | 24 | Three address bytes for the header |
| subHdr | input | 32 | Four subheader bytes (Mode 2) |
| bufRd | output | 1 | Payload read request |
| bufAddr | output | 11 | Payload byte address |
| bufData | input | 8 | Payload byte, one cycle after bufRd |
| parRd | output | 1 | Parity read request |
| parAddr | output | 11 | Parity byte address (0 to 275) |
| parData | input | 8 | Parity byte, one cycle after parRd |
| serClk | output | 1 | Serial bit clock |
| wordSel | output | 1 | Word-select framing |
| serData | output | 1 | Serial sector data |
| sectorDone | output | 1 | One-cycle end-of-sector pulse |

## Verification
Completion of one sector and acceptance of the next can fall in the same cycle, because the idle state is entered and the strobe sampled together. The bench holds startStb high through a whole Mode 2 sector. It also rewrites mode, header, subheader and payload contents late in that sector. The running sector must come out unchanged, exactly one completion pulse must appear, and the chained Mode 1 sector must carry the rewritten inputs. The gap between that pulse and the first new bit clock is judged as well.

// File: rtl/cdenc_pkg.sv
package cdenc_pkg;

  localparam int SECTOR_BYTES = 2352;
  localparam int SYNC_BYTES   = 12;
  localparam int HDR_BYTES    = 4;
  localparam int SUB_BYTES    = 8;
  localparam int USER_BYTES   = 2048;
  localparam int EDC_BYTES    = 4;
  localparam int PAR_BYTES    = 276;
  localparam int PAR_BASE     = SECTOR_BYTES - PAR_BYTES;
  localparam int DATA_BASE_M1 = SYNC_BYTES + HDR_BYTES;
  localparam int DATA_BASE_M2 = DATA_BASE_M1 + SUB_BYTES;

  localparam int HALF_SLOTS     = 49;
  localparam int WS_SLOTS       = 2 * HALF_SLOTS;
  localparam int BYTES_PER_HALF = (HALF_SLOTS - 1) / 8;
  localparam int WS_PERIODS     = SECTOR_BYTES / (2 * BYTES_PER_HALF);

  localparam int IDX_W  = $clog2(SECTOR_BYTES + 1);
  localparam int ADDR_W = $clog2(USER_BYTES);
  localparam int PAR_W  = ADDR_W;
  localparam int SLOT_W = $clog2(WS_SLOTS);
  localparam int WS_W   = $clog2(WS_PERIODS);

  localparam int SCR_W = 15;
  localparam logic [SCR_W-1:0] SCR_SEED = 15'h0001;
  localparam logic [31:0] EDC_POLY_REV  = 32'hD801_8001;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_ONES, SRC_HDR, SRC_MODE, SRC_SUB, SRC_BUF, SRC_EDC, SRC_PAR
  } srcKind_e;

  typedef struct packed {
    srcKind_e   kind;
    logic [1:0] lane;
    logic       crcOn;
    logic       scrOn;
  } byteSel_t;

  typedef struct packed {
    byteSel_t            sel;
    logic [ADDR_W-1:0]   addr;
  } byteDesc_t;

  typedef struct packed {
    logic     init;
    logic     commit;
    byteSel_t sel;
    logic     load;
    logic     shift;
    logic     dataSlot;
  } ctrlStb_t;

  // Where does sector byte idx come from, and which running codes touch it.
  function automatic byteDesc_t decodeIdx(input logic [IDX_W-1:0] idx, input logic modeTwo);
    byteDesc_t d;
    int i;
    int dataBase;
    int edcBase;
    i        = int'(idx);
    dataBase = modeTwo ? DATA_BASE_M2 : DATA_BASE_M1;
    edcBase  = dataBase + USER_BYTES;
    d            = '0;
    d.sel.kind   = SRC_ZERO;
    d.sel.scrOn  = (i >= SYNC_BYTES);
    if (i < SYNC_BYTES) begin
      d.sel.kind  = (i == 0 || i == SYNC_BYTES - 1) ? SRC_ZERO : SRC_ONES;
      d.sel.crcOn = !modeTwo;
    end else if (i < SYNC_BYTES + HDR_BYTES - 1) begin
      d.sel.kind  = SRC_HDR;
      d.sel.lane  = 2'(i - SYNC_BYTES);
      d.sel.crcOn = !modeTwo;
    end else if (i == SYNC_BYTES + HDR_BYTES - 1) begin
      d.sel.kind  = SRC_MODE;
      d.sel.lane  = modeTwo ? 2'd2 : 2'd1;
      d.sel.crcOn = !modeTwo;
    end else if (i < dataBase) begin
      d.sel.kind  = SRC_SUB;
      d.sel.lane  = 2'((i - DATA_BASE_M1) % 4);
      d.sel.crcOn = 1'b1;
    end else if (i < edcBase) begin
      d.sel.kind  = SRC_BUF;
      d.addr      = ADDR_W'(i - dataBase);
      d.sel.crcOn = 1'b1;
    end else if (i < edcBase + EDC_BYTES) begin
      d.sel.kind  = SRC_EDC;
      d.sel.lane  = 2'(i - edcBase);
    end else if (i >= PAR_BASE) begin
      d.sel.kind  = SRC_PAR;
      d.addr      = ADDR_W'(i - PAR_BASE);
    end
    return d;
  endfunction

  function automatic logic [31:0] edcByte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ EDC_POLY_REV) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] scrMask(input logic [SCR_W-1:0] s);
    logic [SCR_W-1:0] t;
    logic [7:0] m;
    t = s;
    for (int k = 0; k < 8; k++) begin
      m[k] = t[0];
      t    = {t[0] ^ t[1], t[SCR_W-1:1]};
    end
    return m;
  endfunction

  function automatic logic [SCR_W-1:0] scrAdv(input logic [SCR_W-1:0] s);
    logic [SCR_W-1:0] t;
    t = s;
    for (int k = 0; k < 8; k++) begin
      t = {t[0] ^ t[1], t[SCR_W-1:1]};
    end
    return t;
  endfunction

endpackage

// File: rtl/cdenc_ctrl.sv
module cdenc_ctrl
  import cdenc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              modeSel,
  output ctrlStb_t          stb,
  output logic              bufRd,
  output logic [ADDR_W-1:0] bufAddr,
  output logic              parRd,
  output logic [PAR_W-1:0]  parAddr,
  output logic              serClk,
  output logic              wordSel,
  output logic              sectorDone
);

  logic              runQ;
  logic              modeQ;
  logic [IDX_W-1:0]  prepIdx;
  logic              pendQ;
  byteSel_t          pendSel;
  logic              nextValid;
  logic              serOn;
  logic              bitPh;
  logic [SLOT_W-1:0] slot;
  logic [WS_W-1:0]   wsCnt;
  logic [2:0]        bitCnt;
  logic              doneQ;

  byteDesc_t fetchDesc;
  logic accept, doFetch, serStart, padSlot, slotEnd, lastSlot;
  logic byteEnd, lastByteEnd, loadNow, shiftNow;

  always_comb begin
    fetchDesc   = decodeIdx(prepIdx, modeQ);
    accept      = !runQ && startStb;
    doFetch     = runQ && !nextValid && !pendQ && (prepIdx < IDX_W'(SECTOR_BYTES));
    serStart    = runQ && !serOn && nextValid;
    padSlot     = (slot == SLOT_W'(HALF_SLOTS - 1)) || (slot == SLOT_W'(WS_SLOTS - 1));
    slotEnd     = serOn && bitPh;
    lastSlot    = slotEnd && (slot == SLOT_W'(WS_SLOTS - 1)) && (wsCnt == WS_W'(WS_PERIODS - 1));
    byteEnd     = slotEnd && !padSlot && (bitCnt == 3'd7);
    lastByteEnd = byteEnd && (wsCnt == WS_W'(WS_PERIODS - 1)) && (slot == SLOT_W'(WS_SLOTS - 2));
    loadNow     = serStart || (byteEnd && !lastByteEnd);
    shiftNow    = slotEnd && !padSlot && !byteEnd;
  end

  always_comb begin
    stb.init     = accept;
    stb.commit   = pendQ;
    stb.sel      = pendSel;
    stb.load     = loadNow;
    stb.shift    = shiftNow;
    stb.dataSlot = serOn && !padSlot;
  end

  assign bufRd      = doFetch && (fetchDesc.sel.kind == SRC_BUF);
  assign parRd      = doFetch && (fetchDesc.sel.kind == SRC_PAR);
  assign bufAddr    = fetchDesc.addr;
  assign parAddr    = fetchDesc.addr;
  assign serClk     = serOn && bitPh;
  assign wordSel    = serOn && (slot >= SLOT_W'(HALF_SLOTS));
  assign sectorDone = doneQ;

  // Byte preparation: fetch one cycle, commit the next.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      modeQ     <= 1'b0;
      prepIdx   <= '0;
      pendQ     <= 1'b0;
      pendSel   <= '0;
      nextValid <= 1'b0;
    end else begin
      if (accept) begin
        runQ      <= 1'b1;
        modeQ     <= modeSel;
        prepIdx   <= '0;
        pendQ     <= 1'b0;
        nextValid <= 1'b0;
      end else begin
        if (lastSlot) runQ <= 1'b0;
        pendQ <= doFetch;
        if (doFetch) pendSel <= fetchDesc.sel;
        if (pendQ) begin
          prepIdx   <= prepIdx + 1'b1;
          nextValid <= 1'b1;
        end else if (loadNow) begin
          nextValid <= 1'b0;
        end
      end
    end
  end

  // Bit-slot sequencing.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      serOn  <= 1'b0;
      bitPh  <= 1'b0;
      slot   <= '0;
      wsCnt  <= '0;
      bitCnt <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= lastSlot;
      if (serStart) begin
        serOn  <= 1'b1;
        bitPh  <= 1'b0;
        slot   <= '0;
        wsCnt  <= '0;
        bitCnt <= '0;
      end else if (serOn) begin
        bitPh <= !bitPh;
        if (slotEnd) begin
          if (!padSlot) bitCnt <= bitCnt + 1'b1;
          if (slot == SLOT_W'(WS_SLOTS - 1)) begin
            slot  <= '0;
            wsCnt <= wsCnt + 1'b1;
          end else begin
            slot <= slot + 1'b1;
          end
          if (lastSlot) serOn <= 1'b0;
        end
      end
    end
  end

  a_r1_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    runQ && startStb |=> $stable(modeQ));
  a_r8_load_ready: assert property (@(posedge clk) disable iff (!rstN)
    loadNow |-> nextValid);
  a_r8_clk_toggle: assert property (@(posedge clk) disable iff (!rstN)
    serOn |=> !serOn || (serClk != $past(serClk)));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    sectorDone |=> !sectorDone);

endmodule

// File: rtl/cdenc_dp.sv
module cdenc_dp
  import cdenc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStb_t    stb,
  input  logic [23:0] hdrIn,
  input  logic [31:0] subIn,
  input  logic [7:0]  bufData,
  input  logic [7:0]  parData,
  output logic        serData
);

  logic [23:0]      hdrQ;
  logic [31:0]      subQ;
  logic [31:0]      crcQ;
  logic [SCR_W-1:0] lfsrQ;
  logic [7:0]       nextQ;
  logic [7:0]       shiftQ;
  logic [7:0]       rawByte;
  logic [7:0]       outByte;

  always_comb begin
    unique case (stb.sel.kind)
      SRC_ZERO: rawByte = 8'h00;
      SRC_ONES: rawByte = 8'hFF;
      SRC_HDR:  rawByte = 8'(hdrQ >> {2'd2 - stb.sel.lane, 3'b000});
      SRC_MODE: rawByte = {6'd0, stb.sel.lane};
      SRC_SUB:  rawByte = 8'(subQ >> {2'd3 - stb.sel.lane, 3'b000});
      SRC_BUF:  rawByte = bufData;
      SRC_EDC:  rawByte = 8'(crcQ >> {stb.sel.lane, 3'b000});
      SRC_PAR:  rawByte = parData;
      default:  rawByte = 8'h00;
    endcase
    outByte = stb.sel.scrOn ? (rawByte ^ scrMask(lfsrQ)) : rawByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrQ   <= '0;
      subQ   <= '0;
      crcQ   <= '0;
      lfsrQ  <= SCR_SEED;
      nextQ  <= '0;
      shiftQ <= '0;
    end else begin
      if (stb.init) begin
        hdrQ  <= hdrIn;
        subQ  <= subIn;
        crcQ  <= '0;
        lfsrQ <= SCR_SEED;
      end else if (stb.commit) begin
        nextQ <= outByte;
        if (stb.sel.crcOn) crcQ  <= edcByte(crcQ, rawByte);
        if (stb.sel.scrOn) lfsrQ <= scrAdv(lfsrQ);
      end
      if (stb.load)       shiftQ <= nextQ;
      else if (stb.shift) shiftQ <= {shiftQ[6:0], 1'b0};
    end
  end

  assign serData = stb.dataSlot && shiftQ[7];

  a_r7_lfsr_live: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);
  a_r5_edc_frozen: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit && (stb.sel.kind == SRC_EDC) |=> $stable(crcQ));

endmodule

// File: rtl/cdenc_serializer.sv
module cdenc_serializer
  import cdenc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStb,
  input  logic              modeSel,
  input  logic [23:0]       hdrAddr,
  input  logic [31:0]       subHdr,
  output logic              bufRd,
  output logic [ADDR_W-1:0] bufAddr,
  input  logic [7:0]        bufData,
  output logic              parRd,
  output logic [PAR_W-1:0]  parAddr,
  input  logic [7:0]        parData,
  output logic              serClk,
  output logic              wordSel,
  output logic              serData,
  output logic              sectorDone
);

  ctrlStb_t stb;

  cdenc_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startStb   (startStb),
    .modeSel    (modeSel),
    .stb        (stb),
    .bufRd      (bufRd),
    .bufAddr    (bufAddr),
    .parRd      (parRd),
    .parAddr    (parAddr),
    .serClk     (serClk),
    .wordSel    (wordSel),
    .sectorDone (sectorDone)
  );

  cdenc_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .hdrIn   (hdrAddr),
    .subIn   (subHdr),
    .bufData (bufData),
    .parData (parData),
    .serData (serData)
  );

endmodule

// File: tb/cdenc_serializer_tb_top.sv
module cdenc_serializer_tb_top;

  localparam int NB    = 2352;
  localparam int NBITS = 196 * 98;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, startStb, modeSel;
  logic [23:0] hdrAddr;
  logic [31:0] subHdr;
  logic        bufRd, parRd;
  logic [10:0] bufAddr, parAddr;
  logic [7:0]  bufData, parData;
  logic        serClk, wordSel, serData, sectorDone;

  cdenc_serializer dut_i (.*);

  int cmpCnt = 0;
  int misCnt = 0;
  int bufSeed = 0;
  int cyc = 0;
  int doneCnt = 0;

  function automatic logic [7:0] bufVal(input int seed, input int a);
    return 8'(a * 7 + seed * 29 + (a >> 5));
  endfunction
  function automatic logic [7:0] parVal(input int a);
    return 8'(a * 13 + 5) ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sectorDone) doneCnt <= doneCnt + 1;
    if (bufRd) bufData <= bufVal(bufSeed, int'(bufAddr));
    if (parRd) parData <= parVal(int'(parAddr));
  end

  logic capWs  [NBITS];
  logic capBit [NBITS];
  int capN = 0;
  int lastRise = 0;
  int firstRise = 0;
  int spacingBad = 0;

  always @(posedge serClk) begin
    if (capN < NBITS) begin
      capWs[capN]  = wordSel;
      capBit[capN] = serData;
    end
    if (capN == 0) firstRise = cyc;
    else if (cyc - lastRise != 2) spacingBad++;
    lastRise = cyc;
    capN++;
  end

  logic [7:0] expRaw [NB];
  logic [7:0] expScr [NB];
  logic [7:0] gotByte [NB];

  task automatic check(input string req, input bit ok, input int got, input int exp);
    cmpCnt++;
    if (!ok) begin
      misCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic buildExp(input bit m2, input logic [23:0] h, input logic [31:0] s, input int seed);
    int db, eb, lo;
    logic [31:0] c;
    logic [14:0] lf;
    logic [7:0] mk;
    db = m2 ? 24 : 16;
    eb = db + 2048;
    lo = m2 ? 16 : 0;
    for (int i = 0; i < NB; i++) expRaw[i] = 8'h00;
    for (int i = 1; i < 11; i++) expRaw[i] = 8'hFF;
    expRaw[12] = h[23:16];
    expRaw[13] = h[15:8];
    expRaw[14] = h[7:0];
    expRaw[15] = m2 ? 8'h02 : 8'h01;
    if (m2) for (int k = 0; k < 8; k++) expRaw[16 + k] = 8'(s >> (8 * (3 - (k % 4))));
    for (int a = 0; a < 2048; a++) expRaw[db + a] = bufVal(seed, a);
    c = 32'd0;
    for (int i = lo; i < eb; i++) begin
      c = c ^ {24'd0, expRaw[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hD8018001) : (c >> 1);
    end
    for (int k = 0; k < 4; k++) expRaw[eb + k] = 8'(c >> (8 * k));
    for (int a = 0; a < 276; a++) expRaw[2076 + a] = parVal(a);
    lf = 15'h0001;
    for (int i = 0; i < NB; i++) begin
      if (i < 12) expScr[i] = expRaw[i];
      else begin
        for (int k = 0; k < 8; k++) begin
          mk[k] = lf[0];
          lf = {lf[0] ^ lf[1], lf[14:1]};
        end
        expScr[i] = expRaw[i] ^ mk;
      end
    end
  endtask

  task automatic checkRange(input string req, input int lo, input int hi);
    int bad, at;
    bad = 0;
    at = lo;
    for (int i = lo; i <= hi; i++) begin
      if (gotByte[i] !== expScr[i]) begin
        if (bad == 0) at = i;
        bad++;
      end
    end
    check(req, bad == 0, int'(gotByte[at]), int'(expScr[at]));
  endtask

  task automatic evalSector(input string nm, input bit m2, input logic [23:0] h,
                            input logic [31:0] s, input int seed);
    int wsBad, padBad, db, eb;
    wsBad = 0;
    padBad = 0;
    $display("checking sector %s", nm);
    buildExp(m2, h, s, seed);
    for (int i = 0; i < NB; i++) gotByte[i] = 8'h00;
    check("R9 bit count", capN == NBITS, capN, NBITS);
    for (int n = 0; n < NBITS; n++) begin
      int per, sl, hf, hp;
      per = n / 98;
      sl  = n % 98;
      hf  = (sl >= 49) ? 1 : 0;
      hp  = sl - 49 * hf;
      if (capWs[n] !== hf[0]) wsBad++;
      if (hp == 48) begin
        if (capBit[n] !== 1'b0) padBad++;
      end else begin
        gotByte[per * 12 + hf * 6 + hp / 8][7 - (hp % 8)] = capBit[n];
      end
    end
    check("R9 wordSel pattern", wsBad == 0, wsBad, 0);
    check("R9 pad bits", padBad == 0, padBad, 0);
    check("R8 bit spacing", spacingBad == 0, spacingBad, 0);
    db = m2 ? 24 : 16;
    eb = db + 2048;
    checkRange("R2 sync", 0, 11);
    checkRange("R3 header", 12, 15);
    if (m2) checkRange("R3 subheader", 16, 23);
    checkRange("R4 payload", db, eb - 1);
    checkRange("R5 edc", eb, eb + 3);
    checkRange("R6 tail", eb + 4, NB - 1);
    checkRange("R7 scrambled body", 12, NB - 1);
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!sectorDone);
  endtask

  task automatic checkIdle(input string req);
    check(req, {serClk, wordSel, serData, sectorDone} == 4'b0,
          int'({serClk, wordSel, serData, sectorDone}), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    cmpCnt++;
    misCnt++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, misCnt);
    $finish;
  end

  initial begin
    int doneAtB, base;
    rstN = 1'b0; startStb = 1'b0; modeSel = 1'b0;
    hdrAddr = '0; subHdr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checkIdle("R10 reset outputs");
    rstN = 1'b1;

    // Sector A: Mode 1; a start and input changes mid-sector must be ignored (R1).
    modeSel = 1'b0; hdrAddr = 24'h01_23_45; subHdr = 32'hDEADBEEF; bufSeed = 3;
    capN = 0; spacingBad = 0;
    base = doneCnt;
    @(negedge clk) startStb = 1'b1;
    @(negedge clk) startStb = 1'b0;
    wait (capN >= 6000);
    @(negedge clk);
    startStb = 1'b1; modeSel = 1'b1; hdrAddr = 24'hFF_00_FF; subHdr = 32'h0;
    @(negedge clk) startStb = 1'b0;
    waitDone();
    evalSector("A R1", 1'b0, 24'h01_23_45, 32'hDEADBEEF, 3);
    repeat (3) @(negedge clk);
    check("R10 single done A", doneCnt - base == 1, doneCnt - base, 1);
    checkIdle("R10 idle outputs");

    // Sector B: Mode 2 with start held; sector C chains in the done cycle (R11).
    modeSel = 1'b1; hdrAddr = 24'h00_02_16; subHdr = 32'h0102_0304; bufSeed = 11;
    capN = 0; spacingBad = 0;
    base = doneCnt;
    @(negedge clk) startStb = 1'b1;
    wait (capN >= 17500);
    @(negedge clk);
    modeSel = 1'b0; hdrAddr = 24'h79_59_74; subHdr = 32'hA5A5_5A5A; bufSeed = 42;
    waitDone();
    doneAtB = cyc;
    evalSector("B R1", 1'b1, 24'h00_02_16, 32'h0102_0304, 11);
    capN = 0; spacingBad = 0;
    @(posedge clk);
    @(negedge clk) startStb = 1'b0;
    waitDone();
    check("R11 chained start gap", (firstRise - doneAtB >= 1) && (firstRise - doneAtB <= 8),
          firstRise - doneAtB, 5);
    evalSector("C R11", 1'b0, 24'h79_59_74, 32'hA5A5_5A5A, 42);
    repeat (3) @(negedge clk);
    check("R10 done count B and C", doneCnt - base == 2, doneCnt - base, 2);
    checkIdle("R10 idle after chain");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, misCnt);
    $finish;
  end

endmodule